// File: doc/BRIEF.md
# Interrupt Acknowledge and Completion Unit

This block sits in an interrupt controller between the per-CPU arbitration logic and the CPU-facing register port. When a CPU reads its acknowledge register, the unit takes the interrupt that the arbiter currently nominates for that CPU and returns its number. For a software-generated interrupt (IDs 0 to 15) it also returns the number of the CPU that raised it. The unit then marks the interrupt as in service and tells the neighbouring logic to drop the pending state, clear that CPU's IRQ line and reset its nominated interrupt.

When a CPU writes its end-of-interrupt register, the unit finds the matching in-service bit and clears it. For a software interrupt this bit belongs to one (source, destination) pair. The unit flags completions that name nothing in service, and it asks the arbiter to re-evaluate. From the in-service set it keeps a running priority for each CPU. Peripheral interrupts in service count for every CPU. Software interrupts count only for their destination CPU.

Top module: `irq_ack_unit`

## Requirements
- R1: The acknowledge word carries the interrupt ID in bits 9:0 and the source CPU in bits 12:10, with bits 31:13 zero. The source field is zero for IDs of 16 and above.
- R2: An acknowledge read while `dist_en` is low or the reader's `cpu_if_en` bit is low returns 1023. It issues no command and changes no in-service bit.
- R3: For a software ID s below 16, the source is the lowest CPU number k for which bit `s*NCPU*NCPU + k*NCPU + reader` of `sgi_pend` is set. The pending-clear command names (s, k, reader), and that pair is marked in service.
- R4: For a peripheral ID (16 up to `NIRQ-1`), the acknowledge marks the ID in service and issues a pending-clear command with the software flag low, source 0 and the reader as destination.
- R5: In the cycle after an accepted acknowledge, `irq_clr` has exactly the reader's bit set, for one cycle. This pulse also tells the arbiter to reset the reader's nominated interrupt to 1023. At all other times `irq_clr` is zero.
- R6: An end-of-interrupt write decodes `wr_data` with the layout of R1. For an ID below 16 it clears pair (source field, writer). For other IDs it clears that ID's in-service bit.
- R7: An end-of-interrupt write whose target bit is not in service raises `eoi_err` for one cycle, one cycle after the write, and changes no state. This includes a source field of `NCPU` or more.
- R8: `run_prio` slot c holds the lowest priority value among the interrupts in service for CPU c, or 0xFF when none are in service. It reflects each acknowledge or completion two cycles after the strobe.
- R9: `rearb` pulses one cycle after a successful completion. It also pulses one cycle after any `cfg_wr` or `eoi_wr` by a CPU whose interface is enabled.
- R10: An accepted read whose nominated ID is 1023 or out of range, or is a software ID with no pending source for the reader, returns 1023 and changes no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dist_en | input | 1 | Global distributor enable |
| cpu_if_en | input | NCPU | Per-CPU interface enable |
| req_cpu | input | CW | CPU issuing the current access |
| ack_rd | input | 1 | Acknowledge register read strobe |
| eoi_wr | input | 1 | End-of-interrupt write strobe |
| cfg_wr | input | 1 | Write strobe to any other interface register |
| wr_data | input | 13 | Low write-data bits (ID 9:0, source 12:10) |
| best_id | input | NCPU*10 | Arbiter's nominated ID per CPU |
| sgi_pend | input | 16*NCPU*NCPU | Software pending pair bits |
| prio | input | NIRQ*8 | Priority per interrupt, lower is more urgent |
| rd_data | output | 32 | Acknowledge read data |
| pend_clr_vld | output | 1 | Pending-clear command valid |
| pend_clr_sgi | output | 1 | Command targets a software pair |
| pend_clr_id | output | 10 | Interrupt ID to clear |
| pend_clr_src | output | 3 | Source CPU of the pair |
| pend_clr_dst | output | CW | Destination CPU of the pair |
| irq_clr | output | NCPU | Per-CPU IRQ clear pulse |
| eoi_err | output | 1 | Completion of a non-active interrupt |
| rearb | output | 1 | Re-arbitration request pulse |
| run_prio | output | NCPU*8 | Running priority per CPU |

## Verification
The bench builds the unit with NCPU=3 and NIRQ=40. Three CPUs make the pair index `k*3+reader` land off byte boundaries, so a stride or source-order mistake shows up as a wrong source or a wrong cleared pair. Source fields 3 to 7 become legal encodings that must be rejected. The 24 peripheral lines keep random completions landing on bits that are really in service, so running-priority changes per CPU are exercised often.

// File: rtl/irq_ack_pkg.sv
`timescale 1ns/1ps
package irq_ack_pkg;
  localparam int ID_W     = 10;
  localparam int SRC_W    = 3;
  localparam int PRIO_W   = 8;
  localparam int NSGI     = 16;
  localparam int PAIR_W   = 6;
  localparam int SPURIOUS = 1023;

  typedef struct packed {
    logic [18:0]      rsvd;
    logic [SRC_W-1:0] src;
    logic [ID_W-1:0]  id;
  } ack_word_t;
endpackage

// File: rtl/irq_src_pick.sv
`timescale 1ns/1ps
module irq_src_pick
  import irq_ack_pkg::*;
#(
  parameter int NCPU = 4,
  parameter int CW   = 2
) (
  input  logic [NCPU*NCPU-1:0] pend_word,
  input  logic [CW-1:0]        reader,
  output logic                 found,
  output logic [SRC_W-1:0]     src
);
  // lowest source wins: scan downward so the last hit is the smallest
  always_comb begin
    found = 1'b0;
    src   = '0;
    for (int s = NCPU - 1; s >= 0; s--) begin
      if (pend_word[s*NCPU + int'(reader)]) begin
        found = 1'b1;
        src   = SRC_W'(s);
      end
    end
  end
endmodule

// File: rtl/irq_act_store.sv
`timescale 1ns/1ps
module irq_act_store
  import irq_ack_pkg::*;
#(
  parameter int NCPU = 4,
  parameter int NIRQ = 64
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        set_en,
  input  logic                        set_sgi,
  input  logic [ID_W-1:0]             set_id,
  input  logic [PAIR_W-1:0]           set_pair,
  input  logic                        clr_en,
  input  logic                        clr_sgi,
  input  logic [ID_W-1:0]             clr_id,
  input  logic [PAIR_W-1:0]           clr_pair,
  input  logic                        q_sgi,
  input  logic [ID_W-1:0]             q_id,
  input  logic [PAIR_W-1:0]           q_pair,
  output logic                        q_hit,
  output logic [NSGI*NCPU*NCPU-1:0]   sgi_act,
  output logic [NIRQ-NSGI-1:0]        per_act
);
  localparam int NN   = NCPU * NCPU;
  localparam int NPER = NIRQ - NSGI;

  logic [NSGI*NN-1:0] sgi_q, sgi_d;
  logic [NPER-1:0]    per_q, per_d;
  int si, pi, ci, pci, qi, qpi;

  always_comb begin
    si  = int'(set_id[3:0]) * NN + int'(set_pair);
    pi  = int'(set_id) - NSGI;
    ci  = int'(clr_id[3:0]) * NN + int'(clr_pair);
    pci = int'(clr_id) - NSGI;
    qi  = int'(q_id[3:0]) * NN + int'(q_pair);
    qpi = int'(q_id) - NSGI;
  end

  always_comb begin
    sgi_d = sgi_q;
    per_d = per_q;
    if (set_en) begin
      if (set_sgi)                     sgi_d[si] = 1'b1;
      else if (pi >= 0 && pi < NPER)   per_d[pi] = 1'b1;
    end
    if (clr_en) begin
      if (clr_sgi)                     sgi_d[ci]  = 1'b0;
      else if (pci >= 0 && pci < NPER) per_d[pci] = 1'b0;
    end
  end

  always_comb begin
    q_hit = 1'b0;
    if (q_sgi)                        q_hit = sgi_q[qi];
    else if (qpi >= 0 && qpi < NPER)  q_hit = per_q[qpi];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sgi_q <= '0;
      per_q <= '0;
    end else if (set_en || clr_en) begin
      sgi_q <= sgi_d;
      per_q <= per_d;
    end
  end

  assign sgi_act = sgi_q;
  assign per_act = per_q;

  p_one_op_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !(set_en && clr_en));
  p_sgi_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
    set_en && set_sgi |=> sgi_act[$past(si)]);
  p_per_set_r4: assert property (@(posedge clk) disable iff (!rst_n)
    set_en && !set_sgi |=> per_act[$past(pi)]);
  p_sgi_clr_r6: assert property (@(posedge clk) disable iff (!rst_n)
    clr_en && clr_sgi |=> !sgi_act[$past(ci)]);
endmodule

// File: rtl/irq_run_prio.sv
`timescale 1ns/1ps
module irq_run_prio
  import irq_ack_pkg::*;
#(
  parameter int NCPU = 4,
  parameter int NIRQ = 64
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       upd,
  input  logic [NSGI*NCPU*NCPU-1:0]  sgi_act,
  input  logic [NIRQ-NSGI-1:0]       per_act,
  input  logic [NIRQ*PRIO_W-1:0]     prio,
  output logic [NCPU*PRIO_W-1:0]     run_prio
);
  localparam int NN = NCPU * NCPU;

  for (genvar c = 0; c < NCPU; c++) begin : g_cpu
    logic [PRIO_W-1:0] min_d, rp_q;

    always_comb begin
      min_d = '1;
      for (int s = 0; s < NSGI; s++) begin
        for (int k = 0; k < NCPU; k++) begin
          if (sgi_act[s*NN + k*NCPU + c] && prio[s*PRIO_W +: PRIO_W] < min_d)
            min_d = prio[s*PRIO_W +: PRIO_W];
        end
      end
      for (int p = NSGI; p < NIRQ; p++) begin
        if (per_act[p-NSGI] && prio[p*PRIO_W +: PRIO_W] < min_d)
          min_d = prio[p*PRIO_W +: PRIO_W];
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   rp_q <= '1;
      else if (upd) rp_q <= min_d;
    end

    assign run_prio[c*PRIO_W +: PRIO_W] = rp_q;
  end

  p_idle_ff_r8: assert property (@(posedge clk) disable iff (!rst_n)
    upd && !(|sgi_act) && !(|per_act) |=> run_prio == '1);
endmodule

// File: rtl/irq_ack_unit.sv
`timescale 1ns/1ps
module irq_ack_unit
  import irq_ack_pkg::*;
#(
  parameter int NCPU = 4,
  parameter int NIRQ = 64,
  parameter int CW   = (NCPU > 1) ? $clog2(NCPU) : 1
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       dist_en,
  input  logic [NCPU-1:0]            cpu_if_en,
  input  logic [CW-1:0]              req_cpu,
  input  logic                       ack_rd,
  input  logic                       eoi_wr,
  input  logic                       cfg_wr,
  input  logic [12:0]                wr_data,
  input  logic [NCPU*ID_W-1:0]       best_id,
  input  logic [NSGI*NCPU*NCPU-1:0]  sgi_pend,
  input  logic [NIRQ*PRIO_W-1:0]     prio,
  output logic [31:0]                rd_data,
  output logic                       pend_clr_vld,
  output logic                       pend_clr_sgi,
  output logic [ID_W-1:0]            pend_clr_id,
  output logic [SRC_W-1:0]           pend_clr_src,
  output logic [CW-1:0]              pend_clr_dst,
  output logic [NCPU-1:0]            irq_clr,
  output logic                       eoi_err,
  output logic                       rearb,
  output logic [NCPU*PRIO_W-1:0]     run_prio
);
  localparam int NN = NCPU * NCPU;
  localparam logic [ID_W-1:0]  SGI_LIM = ID_W'(NSGI);
  localparam logic [ID_W-1:0]  IRQ_LIM = ID_W'(NIRQ);
  localparam logic [SRC_W-1:0] SRC_LIM = SRC_W'(NCPU - 1);

  // ---------------- acknowledge path ----------------
  logic [ID_W-1:0]    rid;
  logic               en_ok, r_sgi, r_per, found, ack_take;
  logic [NN-1:0]      pend_word;
  logic [SRC_W-1:0]   src;
  logic [PAIR_W-1:0]  ack_pair;
  ack_word_t          ack_w;

  always_comb begin
    rid       = best_id[int'(req_cpu)*ID_W +: ID_W];
    en_ok     = dist_en && cpu_if_en[req_cpu];
    r_sgi     = rid < SGI_LIM;
    r_per     = (rid >= SGI_LIM) && (rid < IRQ_LIM);
    pend_word = sgi_pend[int'(rid[3:0])*NN +: NN];
  end

  irq_src_pick #(.NCPU(NCPU), .CW(CW)) u_pick (
    .pend_word (pend_word),
    .reader    (req_cpu),
    .found     (found),
    .src       (src)
  );

  always_comb begin
    ack_take = ack_rd && en_ok && (r_per || (r_sgi && found));
    ack_pair = PAIR_W'(int'(src) * NCPU + int'(req_cpu));
    ack_w    = '0;
    ack_w.id = ID_W'(SPURIOUS);
    if (ack_take) begin
      ack_w.id  = rid;
      ack_w.src = r_sgi ? src : '0;
    end
    rd_data = ack_w;
  end

  // ---------------- completion path ----------------
  logic [ID_W-1:0]    eid;
  logic [SRC_W-1:0]   ecpu;
  logic               e_sgi, q_sgi, q_hit, eoi_go, eoi_ok, eoi_bad;
  logic [PAIR_W-1:0]  eoi_pair;

  always_comb begin
    eid      = wr_data[ID_W-1:0];
    ecpu     = wr_data[12:10];
    e_sgi    = eid < SGI_LIM;
    q_sgi    = e_sgi && (ecpu <= SRC_LIM);
    eoi_pair = PAIR_W'(int'(ecpu) * NCPU + int'(req_cpu));
    eoi_go   = eoi_wr && !ack_rd;
    eoi_ok   = eoi_go && q_hit;
    eoi_bad  = eoi_go && !q_hit;
  end

  logic [NSGI*NN-1:0]    sgi_act;
  logic [NIRQ-NSGI-1:0]  per_act;

  irq_act_store #(.NCPU(NCPU), .NIRQ(NIRQ)) u_store (
    .clk      (clk),
    .rst_n    (rst_n),
    .set_en   (ack_take),
    .set_sgi  (r_sgi),
    .set_id   (rid),
    .set_pair (ack_pair),
    .clr_en   (eoi_ok),
    .clr_sgi  (q_sgi),
    .clr_id   (eid),
    .clr_pair (eoi_pair),
    .q_sgi    (q_sgi),
    .q_id     (eid),
    .q_pair   (eoi_pair),
    .q_hit    (q_hit),
    .sgi_act  (sgi_act),
    .per_act  (per_act)
  );

  // ---------------- registered command outputs ----------------
  logic             vld_d, err_d, rearb_d, upd_d, upd_q;
  logic [NCPU-1:0]  clr_d;

  always_comb begin
    vld_d   = ack_take;
    err_d   = eoi_bad;
    upd_d   = ack_take || eoi_ok;
    rearb_d = eoi_ok || ((cfg_wr || eoi_go) && cpu_if_en[req_cpu]);
    clr_d   = '0;
    if (ack_take) clr_d[req_cpu] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_clr_vld <= 1'b0;
      irq_clr      <= '0;
      eoi_err      <= 1'b0;
      rearb        <= 1'b0;
      upd_q        <= 1'b0;
    end else begin
      pend_clr_vld <= vld_d;
      irq_clr      <= clr_d;
      eoi_err      <= err_d;
      rearb        <= rearb_d;
      upd_q        <= upd_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_clr_sgi <= 1'b0;
      pend_clr_id  <= '0;
      pend_clr_src <= '0;
      pend_clr_dst <= '0;
    end else if (ack_take) begin
      pend_clr_sgi <= r_sgi;
      pend_clr_id  <= rid;
      pend_clr_src <= r_sgi ? src : '0;
      pend_clr_dst <= req_cpu;
    end
  end

  irq_run_prio #(.NCPU(NCPU), .NIRQ(NIRQ)) u_rprio (
    .clk      (clk),
    .rst_n    (rst_n),
    .upd      (upd_q),
    .sgi_act  (sgi_act),
    .per_act  (per_act),
    .prio     (prio),
    .run_prio (run_prio)
  );

  p_off_spurious_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ack_rd && !en_ok |-> rd_data == 32'd1023);
  p_off_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ack_rd && !en_ok |=> !pend_clr_vld && irq_clr == '0);
  p_src_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
    ack_rd && rd_data[9:0] >= 10'd16 |-> rd_data[31:10] == '0);
  p_clr_onehot_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(irq_clr));
  p_clr_dst_r5: assert property (@(posedge clk) disable iff (!rst_n)
    pend_clr_vld |-> irq_clr[pend_clr_dst]);
  p_err_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    eoi_err |-> !pend_clr_vld && $stable(run_prio));
endmodule

// File: tb/irq_ack_unit_tb.sv
`timescale 1ns/1ps
module irq_ack_unit_tb;
  localparam int NCPU = 3;
  localparam int NIRQ = 40;
  localparam int CW   = 2;
  localparam int NN   = NCPU * NCPU;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic                  dist_en, ack_rd, eoi_wr, cfg_wr;
  logic [NCPU-1:0]       cpu_if_en;
  logic [CW-1:0]         req_cpu;
  logic [12:0]           wr_data;
  logic [NCPU*10-1:0]    best_id;
  logic [16*NN-1:0]      sgi_pend;
  logic [NIRQ*8-1:0]     prio;
  logic [31:0]           rd_data;
  logic                  pend_clr_vld, pend_clr_sgi, eoi_err, rearb;
  logic [9:0]            pend_clr_id;
  logic [2:0]            pend_clr_src;
  logic [CW-1:0]         pend_clr_dst;
  logic [NCPU-1:0]       irq_clr;
  logic [NCPU*8-1:0]     run_prio;

  irq_ack_unit #(.NCPU(NCPU), .NIRQ(NIRQ), .CW(CW)) u_dut (
    .clk(clk), .rst_n(rst_n), .dist_en(dist_en), .cpu_if_en(cpu_if_en),
    .req_cpu(req_cpu), .ack_rd(ack_rd), .eoi_wr(eoi_wr), .cfg_wr(cfg_wr),
    .wr_data(wr_data), .best_id(best_id), .sgi_pend(sgi_pend), .prio(prio),
    .rd_data(rd_data), .pend_clr_vld(pend_clr_vld), .pend_clr_sgi(pend_clr_sgi),
    .pend_clr_id(pend_clr_id), .pend_clr_src(pend_clr_src),
    .pend_clr_dst(pend_clr_dst), .irq_clr(irq_clr), .eoi_err(eoi_err),
    .rearb(rearb), .run_prio(run_prio)
  );

  int n_chk = 0;
  int n_err = 0;
  bit done  = 0;
  bit       sact [16][NN];
  bit       pact [NIRQ];
  bit [7:0] pm   [NIRQ];

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: got %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic bit [7:0] exp_run(int c);
    bit [7:0] m = 8'hFF;
    for (int s = 0; s < 16; s++)
      for (int k = 0; k < NCPU; k++)
        if (sact[s][k*NCPU+c] && pm[s] < m) m = pm[s];
    for (int p = 16; p < NIRQ; p++)
      if (pact[p] && pm[p] < m) m = pm[p];
    return m;
  endfunction

  task automatic check_rp(string tag);
    for (int c = 0; c < NCPU; c++)
      chk(tag, {24'b0, run_prio[c*8 +: 8]}, {24'b0, exp_run(c)});
  endtask

  task automatic load_prio();
    for (int i = 0; i < NIRQ; i++) prio[i*8 +: 8] = pm[i];
  endtask

  // acknowledge read by CPU c, nominated id
  task automatic do_ack(int c, bit den, bit [NCPU-1:0] cen, bit [9:0] id);
    bit en, take, sg, fnd;
    int src;
    bit [31:0] exp;
    @(negedge clk);
    dist_en = den; cpu_if_en = cen; req_cpu = CW'(c);
    best_id[c*10 +: 10] = id; ack_rd = 1'b1;
    #1;
    en = den && cen[c];
    sg = id < 16;
    fnd = 0; src = 0;
    if (sg)
      for (int s = NCPU - 1; s >= 0; s--)
        if (sgi_pend[int'(id)*NN + s*NCPU + c]) begin fnd = 1; src = s; end
    take = en && ((id >= 16 && id < NIRQ) || (sg && fnd));
    exp  = take ? {19'b0, sg ? 3'(src) : 3'd0, id} : 32'd1023;
    chk(!en ? "R2 ack data" : (!take ? "R10 ack data" : (sg ? "R3 ack word" : "R1 ack word")),
        rd_data, exp);
    @(posedge clk);
    @(negedge clk);
    ack_rd = 1'b0;
    #1;
    chk(take ? "R3/R4 clr vld" : "R2/R10 no cmd", {31'b0, pend_clr_vld}, {31'b0, take});
    chk("R5 irq_clr", {29'b0, irq_clr}, take ? (32'd1 << c) : 32'd0);
    chk("R9 no rearb on read", {31'b0, rearb}, 32'd0);
    if (take) begin
      chk(sg ? "R3 cmd" : "R4 cmd", {18'b0, pend_clr_sgi, pend_clr_id, pend_clr_src},
          {18'b0, sg, id, sg ? 3'(src) : 3'd0});
      chk("R4 cmd dst", {30'b0, pend_clr_dst}, 32'(c));
      if (sg) sact[id][src*NCPU+c] = 1; else pact[id] = 1;
    end
    @(posedge clk);
    @(negedge clk);
    #1;
    check_rp("R8 run prio after ack");
  endtask

  task automatic do_eoi(int c, bit [NCPU-1:0] cen, bit [2:0] ecpu, bit [9:0] eid);
    bit hit;
    @(negedge clk);
    cpu_if_en = cen; req_cpu = CW'(c); wr_data = {ecpu, eid}; eoi_wr = 1'b1;
    hit = 0;
    if (eid < 16) begin
      if (ecpu < NCPU) hit = sact[eid][int'(ecpu)*NCPU+c];
    end else if (eid < NIRQ) hit = pact[eid];
    @(posedge clk);
    @(negedge clk);
    eoi_wr = 1'b0;
    #1;
    chk("R7 eoi_err", {31'b0, eoi_err}, {31'b0, !hit});
    chk("R9 rearb eoi", {31'b0, rearb}, {31'b0, hit || cen[c]});
    if (hit) begin
      if (eid < 16) sact[eid][int'(ecpu)*NCPU+c] = 0; else pact[eid] = 0;
    end
    @(posedge clk);
    @(negedge clk);
    #1;
    check_rp("R6/R8 run prio after eoi");
  endtask

  task automatic do_cfg(int c, bit [NCPU-1:0] cen);
    @(negedge clk);
    cpu_if_en = cen; req_cpu = CW'(c); cfg_wr = 1'b1;
    @(posedge clk);
    @(negedge clk);
    cfg_wr = 1'b0;
    #1;
    chk("R9 rearb cfg", {31'b0, rearb}, {31'b0, cen[c]});
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_err++;
      $display("FAIL watchdog: got hung expected finish");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_0042));
    dist_en = 1; cpu_if_en = '1; req_cpu = '0; ack_rd = 0; eoi_wr = 0; cfg_wr = 0;
    wr_data = '0; best_id = '0; sgi_pend = '0;
    for (int i = 0; i < NIRQ; i++) pm[i] = 8'($urandom_range(16, 250));
    pm[5] = 8'h40; pm[20] = 8'h30; pm[21] = 8'h90;
    load_prio();
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    #1;
    chk("R2 reset rd", rd_data, 32'd1023);
    chk("R5 reset irq_clr", {29'b0, irq_clr}, 32'd0);
    chk("R7 reset err", {30'b0, eoi_err, pend_clr_vld}, 32'd0);
    chk("R9 reset rearb", {31'b0, rearb}, 32'd0);
    check_rp("R8 reset run prio");

    // SGI 5 pending for CPU0 from sources 2 and 1: lowest source wins
    sgi_pend[5*NN + 1*NCPU + 0] = 1'b1;
    sgi_pend[5*NN + 2*NCPU + 0] = 1'b1;
    do_ack(0, 1, 3'b111, 10'd5);
    do_ack(1, 1, 3'b111, 10'd20);
    do_ack(2, 0, 3'b111, 10'd21);
    do_ack(2, 1, 3'b011, 10'd21);
    do_ack(2, 1, 3'b111, 10'd1023);
    do_ack(1, 1, 3'b111, 10'd5);
    do_eoi(0, 3'b111, 3'd1, 10'd5);
    do_eoi(0, 3'b111, 3'd1, 10'd5);
    do_eoi(2, 3'b111, 3'd0, 10'd20);
    do_eoi(1, 3'b101, 3'd5, 10'd3);
    do_eoi(1, 3'b101, 3'd0, 10'd33);
    do_cfg(0, 3'b001);
    do_cfg(1, 3'b001);

    for (int it = 0; it < 500; it++) begin
      int op = $urandom_range(0, 9);
      int c  = $urandom_range(0, NCPU-1);
      bit [NCPU-1:0] cen = ($urandom_range(0, 9) == 0) ? NCPU'($urandom) : '1;
      if (op < 5) begin
        int pk = $urandom_range(0, 9);
        bit [9:0] id = (pk < 5) ? 10'($urandom_range(0, 15)) :
                       (pk < 9) ? 10'($urandom_range(16, NIRQ-1)) : 10'd1023;
        for (int b = 0; b < 16*NN; b++) sgi_pend[b] = ($urandom_range(0, 3) == 0);
        for (int k = 0; k < NCPU; k++) if (k != c) best_id[k*10 +: 10] = 10'($urandom);
        do_ack(c, $urandom_range(0, 9) != 0, cen, id);
      end else if (op < 9) begin
        bit [2:0] ec = 3'($urandom_range(0, 7));
        bit [9:0] ei = 10'($urandom_range(0, NIRQ));
        for (int t = 0; t < 30; t++) begin
          int s = $urandom_range(0, NIRQ-1);
          int k = $urandom_range(0, NCPU-1);
          if (s < 16 && sact[s][k*NCPU+c]) begin ec = 3'(k); ei = 10'(s); break; end
          if (s >= 16 && pact[s]) begin ec = 3'($urandom_range(0, 7)); ei = 10'(s); break; end
        end
        do_eoi(c, cen, ec, ei);
      end else begin
        do_cfg(c, cen);
      end
    end

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
    $finish;
  end
endmodule